// File: doc/BRIEF.md
# Multiplexed Address/Data Pseudo-SRAM Controller

This block sits on the host side of a pseudo-SRAM whose address and data share one 16-bit bidirectional bus. It accepts one request at a time through a valid/ready handshake. Each request carries an 18-bit word address, 16 bits of write data, a 2-bit byte-lane mask and a write flag. The controller turns each request into a two-stage bus sequence. First comes an address stage, in which the low 16 address bits sit on the shared bus and the top 2 bits on dedicated pins, framed by an address-valid strobe. Then comes a data stage, which is either an output-enabled read or a write-enable pulse. A read returns its data with a one-cycle done pulse. A write pulses done in the cycle its write strobe rises.

Every analogue timing window is a minimum in nanoseconds. Each one is turned into a whole number of clock cycles at elaboration from the clock-period parameter, always rounding up. After reset the controller keeps the memory deselected for a power-up wait, 200 µs by default, before it offers ready. After every read it inserts a bus turnaround before the next address stage.

Top module: `muxpsram_ctrl`

## Requirements
- R1: After reset release, `req_ready` stays low and `mem_cs_n` stays high for exactly ceil(POWERUP_NS / CLK_PERIOD_NS) cycles, then `req_ready` rises (10000 cycles with the defaults).
- R2: A request is taken only when `req_valid` and `req_ready` are both high at a clock edge. `req_ready` is high only while the controller is idle and powered up. It drops in the cycle after acceptance, and a request presented during the power-up wait has no effect on memory.
- R3: In the address stage, `mem_cs_n` falls at least one cycle before `mem_avd_n` falls. `mem_avd_n` stays low at least ceil(15 ns / period) cycles and at most floor(1000 ns / period) cycles. While `mem_avd_n` is low, `{mem_a_hi, mem_adq}` equals the request address, and the address stays driven for one more cycle after `mem_avd_n` rises.
- R4: For a read, the controller releases `mem_adq` at least one cycle before `mem_oe_n` falls and never drives the bus while `mem_oe_n` is low. The data is captured at least ceil(25 ns / period) cycles after `mem_oe_n` falls and at least ceil(70 ns / period) cycles after `mem_avd_n` falls. It is presented on `rsp_rdata` with a one-cycle `rsp_done`.
- R5: The mask drives the lane strobes in the data stage: `mem_lb_n` = not mask[0] (lane `mem_adq[7:0]`) and `mem_ub_n` = not mask[1] (lane `mem_adq[15:8]`). So 01 selects the lower byte, 10 the upper byte and 11 the full word. Mask 00 runs a bus cycle with neither lane enabled and leaves memory unchanged.
- R6: For a write, `mem_we_n` is low for at least ceil(45 ns / period) cycles and rises at least ceil(70 ns / period) cycles after `mem_avd_n` fell. The write data is on `mem_adq` for the whole low time. `rsp_done` is high in the cycle `mem_we_n` rises, and `mem_we_n` and `mem_oe_n` are never low together.
- R7: Read-data lanes that the mask did not select are returned as zero on `rsp_rdata`.
- R8: After a read's done pulse, `mem_cs_n` stays high for at least 2 cycles of turnaround. A back-to-back request therefore drops `mem_cs_n` no sooner than 3 cycles after that pulse.
- R9: While reset is held, `mem_cs_n`, `mem_avd_n`, `mem_oe_n` and `mem_we_n` are high, and `rsp_done` and `req_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and powered up |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte-lane mask, bit 0 lower, bit 1 upper |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_avd_n | output | 1 | Address-valid strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Lower lane strobe, active low |
| mem_ub_n | output | 1 | Upper lane strobe, active low |
| mem_a_hi | output | 2 | Upper address bits |
| mem_adq | inout | 16 | Shared address/data bus |

## Verification
The hardest situation to reach from the ports is a read followed straight away by another request. That is the only place where a short turnaround would let the next address stage overlap the memory's output turn-off. The bench issues requests back to back, raising the next valid in the cycle right after the read's done pulse, and measures the gap to the next chip-select fall. The other hard case is a request offered during the power-up wait. The bench holds one up for most of that wait and later reads its address back to show it never landed.

// File: rtl/muxpsram_pkg.sv
package muxpsram_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SETUP, ST_ADDR, ST_HOLD, ST_REL, ST_RD, ST_WR, ST_WEND, ST_TURN
  } mp_state_e;

  typedef struct packed {
    logic cs_n;
    logic avd_n;
    logic oe_n;
    logic we_n;
    logic lanes_on;
    logic drv_addr;
    logic drv_data;
  } mp_ctl_t;

  function automatic int mp_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // whole cycles covering a minimum time, never less than one
  function automatic int mp_cycles(input int ns, input int period);
    return mp_max(1, (ns + period - 1) / period);
  endfunction

  // bus control levels held during each state
  function automatic mp_ctl_t mp_decode(input mp_state_e s);
    mp_ctl_t c;
    c = '{cs_n: 1'b1, avd_n: 1'b1, oe_n: 1'b1, we_n: 1'b1,
          lanes_on: 1'b0, drv_addr: 1'b0, drv_data: 1'b0};
    case (s)
      ST_SETUP: begin c.cs_n = 1'b0; c.drv_addr = 1'b1; end
      ST_ADDR:  begin c.cs_n = 1'b0; c.avd_n = 1'b0; c.drv_addr = 1'b1; end
      ST_HOLD:  begin c.cs_n = 1'b0; c.drv_addr = 1'b1; end
      ST_REL:   begin c.cs_n = 1'b0; end
      ST_RD:    begin c.cs_n = 1'b0; c.oe_n = 1'b0; c.lanes_on = 1'b1; end
      ST_WR:    begin c.cs_n = 1'b0; c.we_n = 1'b0; c.lanes_on = 1'b1; c.drv_data = 1'b1; end
      ST_WEND:  begin c.cs_n = 1'b0; c.lanes_on = 1'b1; c.drv_data = 1'b1; end
      default:  ;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/muxpsram_powerup.sv
module muxpsram_powerup #(
  parameter int CYCLES = 10000
) (
  input  logic clk,
  input  logic rst,
  output logic ok
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      ok  <= 1'b0;
    end else if (!ok) begin
      if (cnt == CW'(CYCLES - 1)) ok <= 1'b1;
      cnt <= cnt + 1'b1;
    end
  end

  // R1: once the wait is over it never comes back
  assert_ok_sticky_R1: assert property (@(posedge clk) disable iff (rst) ok |=> ok);

endmodule

// File: rtl/muxpsram_timer.sv
module muxpsram_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         zero
);
  logic [W-1:0] cnt;

  // a state loaded with N lasts exactly N cycles
  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= val - 1'b1;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/muxpsram_seq.sv
module muxpsram_seq
  import muxpsram_pkg::*;
#(
  parameter int AW            = 18,
  parameter int DW            = 16,
  parameter int CLK_PERIOD_NS = 20,
  parameter int T_CSS_NS      = 7,
  parameter int T_AVDL_NS     = 15,
  parameter int T_AVDL_MAX_NS = 1000,
  parameter int T_AVDS_NS     = 15,
  parameter int T_AVDH_NS     = 5,
  parameter int T_ACC_NS      = 70,
  parameter int T_OE_NS       = 25,
  parameter int T_WRL_NS      = 45,
  parameter int T_DW_NS       = 25,
  parameter int T_BW_NS       = 50,
  parameter int T_HZ_NS       = 15,
  parameter int TURN_MIN      = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pwr_ok,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [AW-1:0]      req_addr,
  input  logic [DW-1:0]      req_wdata,
  input  logic [DW/8-1:0]    req_mask,
  output logic               rsp_done,
  output logic [DW-1:0]      rsp_rdata,
  output logic               cs_n,
  output logic               avd_n,
  output logic               oe_n,
  output logic               we_n,
  output logic               lb_n,
  output logic               ub_n,
  output logic [AW-DW-1:0]   a_hi,
  output logic [DW-1:0]      bus_out,
  output logic               bus_oe,
  input  logic [DW-1:0]      bus_in
);
  localparam int BE      = DW / 8;
  localparam int C_CSS   = mp_cycles(T_CSS_NS, CLK_PERIOD_NS);
  localparam int C_AVDL  = mp_max(mp_cycles(T_AVDL_NS, CLK_PERIOD_NS),
                                  mp_cycles(T_AVDS_NS, CLK_PERIOD_NS) - C_CSS);
  localparam int C_AVDH  = mp_cycles(T_AVDH_NS, CLK_PERIOD_NS);
  localparam int C_ACC   = mp_cycles(T_ACC_NS, CLK_PERIOD_NS);
  localparam int C_RDW   = mp_max(mp_cycles(T_OE_NS, CLK_PERIOD_NS), C_ACC - (C_AVDL + C_AVDH + 1));
  localparam int C_WR    = mp_max(mp_max(mp_cycles(T_WRL_NS, CLK_PERIOD_NS), mp_cycles(T_DW_NS, CLK_PERIOD_NS)),
                                  mp_max(mp_cycles(T_BW_NS, CLK_PERIOD_NS), C_ACC - (C_AVDL + C_AVDH)));
  localparam int C_TURN  = mp_max(TURN_MIN, mp_cycles(T_HZ_NS, CLK_PERIOD_NS));
  localparam int C_AVDMX = T_AVDL_MAX_NS / CLK_PERIOD_NS;
  localparam int MAXD    = mp_max(mp_max(C_CSS, C_AVDL), mp_max(mp_max(C_AVDH, C_RDW), mp_max(C_WR, C_TURN)));
  localparam int TW      = $clog2(MAXD + 1);

  mp_state_e       st_q, st_n;
  logic            ld, t_zero;
  logic [TW-1:0]   ld_val;
  logic            accept;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wdata_q;
  logic [BE-1:0]   mask_q;
  logic            wr_q;
  logic [DW-1:0]   lane_keep;
  mp_ctl_t         nd;
  logic [15:0]     avd_run;

  muxpsram_timer #(.W(TW)) u_timer (
    .clk(clk), .rst(rst), .load(ld), .val(ld_val), .zero(t_zero)
  );

  assign req_ready = pwr_ok && (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  always_comb begin
    st_n   = st_q;
    ld     = 1'b0;
    ld_val = '0;
    case (st_q)
      ST_IDLE:  if (accept) begin st_n = ST_SETUP; ld = 1'b1; ld_val = TW'(C_CSS); end
      ST_SETUP: if (t_zero) begin st_n = ST_ADDR;  ld = 1'b1; ld_val = TW'(C_AVDL); end
      ST_ADDR:  if (t_zero) begin st_n = ST_HOLD;  ld = 1'b1; ld_val = TW'(C_AVDH); end
      ST_HOLD:  if (t_zero) begin
                  ld = 1'b1;
                  if (wr_q) begin st_n = ST_WR;  ld_val = TW'(C_WR); end
                  else      begin st_n = ST_REL; ld_val = TW'(1); end
                end
      ST_REL:   if (t_zero) begin st_n = ST_RD;   ld = 1'b1; ld_val = TW'(C_RDW); end
      ST_RD:    if (t_zero) begin st_n = ST_TURN; ld = 1'b1; ld_val = TW'(C_TURN); end
      ST_WR:    if (t_zero) begin st_n = ST_WEND; ld = 1'b1; ld_val = TW'(1); end
      ST_WEND:  if (t_zero) st_n = ST_IDLE;
      ST_TURN:  if (t_zero) st_n = ST_IDLE;
      default:  st_n = ST_IDLE;
    endcase
  end

  assign nd = mp_decode(st_n);

  generate
    for (genvar b = 0; b < BE; b++) begin : g_lane
      assign lane_keep[b*8 +: 8] = {8{mask_q[b]}};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
      wr_q    <= 1'b0;
    end else begin
      st_q <= st_n;
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        mask_q  <= req_mask;
        wr_q    <= req_write;
      end
    end
  end

  // registered pin levels, aligned with the state they belong to
  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n      <= 1'b1;
      avd_n     <= 1'b1;
      oe_n      <= 1'b1;
      we_n      <= 1'b1;
      lb_n      <= 1'b1;
      ub_n      <= 1'b1;
      bus_oe    <= 1'b0;
      bus_out   <= '0;
      a_hi      <= '0;
      rsp_done  <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      cs_n     <= nd.cs_n;
      avd_n    <= nd.avd_n;
      oe_n     <= nd.oe_n;
      we_n     <= nd.we_n;
      lb_n     <= !(nd.lanes_on && mask_q[0]);
      ub_n     <= !(nd.lanes_on && mask_q[BE-1]);
      bus_oe   <= nd.drv_addr || nd.drv_data;
      bus_out  <= nd.drv_data ? wdata_q : (accept ? req_addr[DW-1:0] : addr_q[DW-1:0]);
      if (accept) a_hi <= req_addr[AW-1:DW];
      rsp_done <= t_zero && ((st_q == ST_RD) || (st_q == ST_WR));
      if (t_zero && (st_q == ST_RD)) rsp_rdata <= bus_in & lane_keep;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        avd_run <= '0;
    else if (avd_n) avd_run <= '0;
    else            avd_run <= avd_run + 1'b1;
  end

  assert_ready_idle_R2: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (cs_n && avd_n && oe_n && we_n));
  assert_addr_on_avd_R3: assert property (@(posedge clk) disable iff (rst)
    !avd_n |-> (bus_oe && !cs_n));
  assert_avd_max_R3: assert property (@(posedge clk) disable iff (rst)
    !avd_n |-> (avd_run < 16'(C_AVDMX)));
  assert_oe_after_release_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(oe_n) |-> $past(!bus_oe));
  assert_no_drive_oe_R4: assert property (@(posedge clk) disable iff (rst)
    !oe_n |-> !bus_oe);
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);
  assert_we_oe_excl_R6: assert property (@(posedge clk) disable iff (rst)
    !(!we_n && !oe_n));
  assert_turnaround_R8: assert property (@(posedge clk) disable iff (rst)
    (rsp_done && cs_n) |=> cs_n);

endmodule

// File: rtl/muxpsram_ctrl.sv
module muxpsram_ctrl
  import muxpsram_pkg::*;
#(
  parameter int AW            = 18,
  parameter int DW            = 16,
  parameter int CLK_PERIOD_NS = 20,
  parameter int POWERUP_NS    = 200000,
  parameter int TURN_MIN      = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [AW-1:0]      req_addr,
  input  logic [DW-1:0]      req_wdata,
  input  logic [DW/8-1:0]    req_mask,
  output logic               rsp_done,
  output logic [DW-1:0]      rsp_rdata,
  output logic               mem_cs_n,
  output logic               mem_avd_n,
  output logic               mem_oe_n,
  output logic               mem_we_n,
  output logic               mem_lb_n,
  output logic               mem_ub_n,
  output logic [AW-DW-1:0]   mem_a_hi,
  inout  wire  [DW-1:0]      mem_adq
);
  localparam int C_PWR = mp_cycles(POWERUP_NS, CLK_PERIOD_NS);

  logic          pwr_ok;
  logic [DW-1:0] bus_out;
  logic          bus_oe;
  logic [DW-1:0] bus_in;

  muxpsram_powerup #(.CYCLES(C_PWR)) u_pwr (
    .clk(clk), .rst(rst), .ok(pwr_ok)
  );

  muxpsram_seq #(
    .AW(AW), .DW(DW), .CLK_PERIOD_NS(CLK_PERIOD_NS), .TURN_MIN(TURN_MIN)
  ) u_seq (
    .clk(clk), .rst(rst), .pwr_ok(pwr_ok),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .cs_n(mem_cs_n), .avd_n(mem_avd_n), .oe_n(mem_oe_n), .we_n(mem_we_n),
    .lb_n(mem_lb_n), .ub_n(mem_ub_n), .a_hi(mem_a_hi),
    .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in)
  );

  assign mem_adq = bus_oe ? bus_out : 'z;
  assign bus_in  = mem_adq;

  assert_powerup_cs_R1: assert property (@(posedge clk) disable iff (rst)
    !pwr_ok |-> mem_cs_n);
  assert_ready_after_pwr_R1: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> pwr_ok);

endmodule

// File: tb/muxpsram_ctrl_test.sv
`timescale 1ns/1ps
module muxpsram_ctrl_test;
  localparam int PER   = 20;
  localparam int C_PWR = 200000 / PER;
  localparam int NV    = 13;

  function automatic int ceilc(input int ns);
    return (ns + PER - 1) / PER;
  endfunction

  // {write, mask[1:0], addr[17:0], data[15:0]}
  localparam logic [36:0] VEC [NV] = '{
    {1'b1, 2'b11, 18'h00010, 16'h1234},
    {1'b0, 2'b11, 18'h00010, 16'h0000},
    {1'b1, 2'b01, 18'h3FFFF, 16'h55AA},
    {1'b0, 2'b11, 18'h3FFFF, 16'h0000},
    {1'b1, 2'b10, 18'h3FFFF, 16'hC3EE},
    {1'b0, 2'b11, 18'h3FFFF, 16'h0000},
    {1'b0, 2'b01, 18'h00010, 16'h0000},
    {1'b0, 2'b10, 18'h00010, 16'h0000},
    {1'b1, 2'b11, 18'h20000, 16'hFFFF},
    {1'b0, 2'b11, 18'h20000, 16'h0000},
    {1'b1, 2'b00, 18'h20000, 16'h0000},
    {1'b0, 2'b11, 18'h20000, 16'h0000},
    {1'b0, 2'b11, 18'h00000, 16'h0000}
  };

  logic        clk = 0;
  logic        rst = 1;
  logic        req_valid = 0, req_write = 0;
  logic [17:0] req_addr = 0;
  logic [15:0] req_wdata = 0;
  logic [1:0]  req_mask = 0;
  logic        req_ready, rsp_done;
  logic [15:0] rsp_rdata;
  logic        cs_n, avd_n, oe_n, we_n, lb_n, ub_n;
  logic [1:0]  a_hi;
  wire  [15:0] adq;

  int total = 0, fails = 0;
  bit started = 0;

  muxpsram_ctrl uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .mem_cs_n(cs_n), .mem_avd_n(avd_n), .mem_oe_n(oe_n), .mem_we_n(we_n),
    .mem_lb_n(lb_n), .mem_ub_n(ub_n), .mem_a_hi(a_hi), .mem_adq(adq)
  );

  always #(PER/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] dflt(input logic [17:0] a);
    return a[15:0] ^ 16'h5A5A;
  endfunction

  // memory model on the shared bus
  logic [15:0] mem [int];
  logic [17:0] m_addr = 0;
  function automatic logic [15:0] m_word(input logic [17:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : dflt(a);
  endfunction
  always @(posedge avd_n) if (!rst && !cs_n) m_addr = {a_hi, adq};
  always @(posedge we_n) if (!rst && !cs_n) begin
    logic [15:0] w;
    w = m_word(m_addr);
    if (!lb_n) w[7:0]  = adq[7:0];
    if (!ub_n) w[15:8] = adq[15:8];
    mem[int'(m_addr)] = w;
  end
  assign adq = (!cs_n && !oe_n) ? m_word(m_addr) : 16'hzzzz;

  // independent reference contents
  logic [15:0] ref_mem [int];
  function automatic logic [15:0] r_word(input logic [17:0] a);
    return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : dflt(a);
  endfunction

  logic [17:0] cur_addr = 0;
  logic [15:0] cur_wdata = 0;
  logic [1:0]  cur_mask = 0;

  task automatic do_op(input logic w, input logic [17:0] a, input logic [15:0] d,
                       input logic [1:0] m, output logic [15:0] rd);
    @(negedge clk);
    cur_addr = a; cur_wdata = d; cur_mask = m;
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d; req_mask = m;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready, "R2 ready low after accept", req_ready, 0);
    while (!rsp_done) @(negedge clk);
    rd = rsp_rdata;
    if (w) begin
      logic [15:0] x;
      x = r_word(a);
      if (m[0]) x[7:0]  = d[7:0];
      if (m[1]) x[15:8] = d[15:8];
      ref_mem[int'(a)] = x;
    end
  endtask

  // bus-timing monitor
  int cyc = 0, t_avd = 0, t_oe = 0, t_we = 0, t_rdone = -100, avd_low = 0;
  logic p_cs = 1, p_avd = 1, p_oe = 1, p_we = 1;
  always @(negedge clk) begin
    cyc++;
    if (started && !rst) begin
      if (!cs_n && p_cs) begin
        chk(avd_n, "R3 cs falls before avd", avd_n, 1);
        chk(cyc - t_rdone >= 3, "R8 turnaround after read", cyc - t_rdone, 3);
      end
      if (!avd_n) begin
        avd_low++;
        if (p_avd) t_avd = cyc;
        chk({a_hi, adq} == cur_addr, "R3 address on bus", {a_hi, adq}, cur_addr);
      end else if (!p_avd) begin
        chk(avd_low >= ceilc(15) && avd_low <= 1000 / PER, "R3 avd low width", avd_low, ceilc(15));
        chk({a_hi, adq} == cur_addr, "R3 address hold", {a_hi, adq}, cur_addr);
        avd_low = 0;
      end
      if (!oe_n) begin
        if (p_oe) t_oe = cyc;
        chk({ub_n, lb_n} == ~cur_mask, "R5 lane strobes read", {ub_n, lb_n}, ~cur_mask);
      end
      if (!we_n) begin
        if (p_we) t_we = cyc;
        chk({ub_n, lb_n} == ~cur_mask, "R5 lane strobes write", {ub_n, lb_n}, ~cur_mask);
        chk(adq == cur_wdata, "R6 write data on bus", adq, cur_wdata);
        chk(oe_n, "R6 oe high during write", oe_n, 1);
      end else if (!p_we) begin
        chk(cyc - t_we >= ceilc(45), "R6 we low width", cyc - t_we, ceilc(45));
        chk(cyc - t_avd >= ceilc(70), "R6 write end after avd", cyc - t_avd, ceilc(70));
        chk(rsp_done, "R6 done as we rises", rsp_done, 1);
      end
      if (rsp_done && cs_n) begin
        chk(cyc - t_oe >= ceilc(25), "R4 sample after oe", cyc - t_oe, ceilc(25));
        chk(cyc - t_avd >= ceilc(70), "R4 sample after avd", cyc - t_avd, ceilc(70));
        t_rdone = cyc;
      end
    end
    p_cs = cs_n; p_avd = avd_n; p_oe = oe_n; p_we = we_n;
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [15:0] rd, exp;
    int n;
    bit cs_bad;
    repeat (4) @(negedge clk);
    // R9: reset state
    chk(cs_n && avd_n && oe_n && we_n, "R9 strobes high in reset", {cs_n, avd_n, oe_n, we_n}, 4'hF);
    chk(!rsp_done, "R9 done low in reset", rsp_done, 0);
    chk(!req_ready, "R9 ready low in reset", req_ready, 0);
    rst = 0;
    // R1: power-up wait; R2: a request during it is ignored
    n = 0; cs_bad = 0;
    while (1) begin
      @(negedge clk);
      n++;
      if (n == 10) begin
        req_valid = 1; req_write = 1; req_addr = 18'h01234; req_wdata = 16'hDEAD; req_mask = 2'b11;
      end
      if (n == C_PWR - 5) req_valid = 0;
      if (req_ready || n > C_PWR + 10) break;
      if (!cs_n) cs_bad = 1;
    end
    chk(n == C_PWR, "R1 ready after power-up", n, C_PWR);
    chk(!cs_bad, "R1 cs high during power-up", cs_bad, 0);
    started = 1;
    // table walk
    for (int i = 0; i < NV; i++) begin
      logic w;
      logic [1:0] m;
      logic [17:0] a;
      logic [15:0] d;
      {w, m, a, d} = VEC[i];
      do_op(w, a, d, m, rd);
      if (!w) begin
        exp = r_word(a) & {{8{m[1]}}, {8{m[0]}}};
        chk(rd == exp, (m == 2'b11) ? "R5 word read" : "R7 masked lanes zero", rd, exp);
      end
    end
    // R2: the write offered during power-up never landed
    do_op(0, 18'h01234, 0, 2'b11, rd);
    chk(rd == dflt(18'h01234), "R2 request during wait ignored", rd, dflt(18'h01234));
    // R5: mask 00 write has no effect, seen by read-back
    do_op(1, 18'h00010, 16'h0F0F, 2'b00, rd);
    do_op(0, 18'h00010, 0, 2'b11, rd);
    chk(rd == 16'h1234, "R5 empty mask leaves memory", rd, 16'h1234);
    // R4/R8: back-to-back reads
    do_op(0, 18'h3FFFF, 0, 2'b11, rd);
    do_op(0, 18'h3FFFF, 0, 2'b10, rd);
    chk(rd == 16'hC300, "R4 upper byte read", rd, 16'hC300);
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule